// File: doc/BRIEF.md
# Byte-Lane Asynchronous SRAM Controller

This block lets a clocked host reach an external static RAM that has no clock of its own. The memory holds 262,144 words of 16 bits behind 18 address lines and one shared, bidirectional 16-bit data bus split into two 8-bit lanes. The host raises a request with an address, a write flag, two lane-select bits and write data, and holds it until a one-cycle ready pulse. For reads, the registered read data is valid in the same cycle as that pulse.

On the memory side the controller drives active-low strobes for chip select, output enable, write enable and the two lane enables. Every strobe is a register output. It also drives the write data with a separate driver enable for each lane. Each pin interval is a whole number of system clocks. That number is derived from a nanosecond figure: the figure is divided by the clock period and rounded up, and one clock of margin is added. A write opens its window with write enable, which falls after the other strobes are already low. Write enable also rises first, so it closes the window. Only the selected lanes are enabled or driven. The data drivers and the memory's output enable are never active together.

Top module: `sram_lane_ctrl`

## Requirements
- R1: The word address on `mem_addr` (18 bits) equals the request's address and stays unchanged for as long as `mem_ce_n` is low.
- R2: `mem_we_n` is low only while `mem_ce_n` is low, at least one lane enable is low and `mem_oe_n` is high. Each low pulse lasts at least WR_CYC cycles (7 with the defaults). At its rising edge the selected lanes are stored: `req_be[0]` selects bits 7:0 and `req_be[1]` selects bits 15:8.
- R3: Only lanes whose `req_be` bit is 1 get their `mem_be_n` bit low and their `mem_dq_oe` bit high. A lane that was not selected returns 0 in `rsp_rdata`.
- R4: `mem_dq_oe` is never nonzero while `mem_oe_n` is low. The drivers turn on only after `mem_oe_n` has been high for at least TURN_CYC cycles (4 with the defaults).
- R5: A read holds `mem_ce_n` and `mem_oe_n` low with `mem_we_n` high for RD_CYC cycles (8 with the defaults). The bus is captured on the last of those cycles.
- R6: In a write, `mem_ce_n` is already low when `mem_we_n` falls, and it is still low when `mem_we_n` rises. Between two writes, `mem_ce_n` returns high for at least one cycle.
- R7: A request with `req_be` = 0 causes no strobe activity. It still completes with a ready pulse, and a read of that kind returns 0.
- R8: `rsp_ready` is high for exactly one cycle per request. A request is accepted only while the controller is idle, and the host holds it until ready.
- R9: While `rst_n` is sampled low, all strobes go high, the drivers turn off and `rsp_ready` goes low, even in the middle of an access.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Request present, held until ready |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 18 | Word address |
| req_be | input | 2 | Lane select, bit 0 = low byte |
| req_wdata | input | 16 | Write data |
| rsp_ready | output | 1 | One-cycle completion pulse |
| rsp_rdata | output | 16 | Read data, unselected lanes zero |
| mem_addr | output | 18 | Memory address |
| mem_ce_n | output | 1 | Chip select, active low |
| mem_oe_n | output | 1 | Memory output enable, active low |
| mem_we_n | output | 1 | Write strobe, active low |
| mem_be_n | output | 2 | Lane enables, active low, bit 0 = low byte |
| mem_dq_out | output | 16 | Data toward memory |
| mem_dq_oe | output | 2 | Per-lane driver enable |
| mem_dq_in | input | 16 | Data from memory |

## Verification
Two events can meet in one cycle. The first is the capture of read data together with the ready pulse. The second is the drop of output enable followed straight away by a write that needs the bus turned around. The bench sends a write immediately after a read. A bus model in the bench drives deliberate garbage until output enable has been low for the full access window. A capture taken even one cycle early therefore shows up as wrong data. The same model counts how long output enable has been high when the drivers turn on, and it flags any overlap between the drivers and output enable.

// File: rtl/sram_lane_pkg.sv
// Shared types and helpers for the byte-lane SRAM controller.
// Assumes all timing figures are positive integers in nanoseconds.
package sram_lane_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_WSETUP,
        ST_WPULSE,
        ST_WHOLD,
        ST_RACC,
        ST_RECOVER
    } ctrl_state_t;

    // Clock count for a nanosecond minimum: rounded-up quotient plus one margin clock.
    function automatic int unsigned ns_to_cyc(input int unsigned ns, input int unsigned clk_ns);
        return (ns + clk_ns - 1) / clk_ns + 1;
    endfunction

endpackage

// File: rtl/sram_tick_timer.sv
// Down-counter used to time the strobe windows.
// Loading N-1 on entry to a state makes that state last N cycles.
// Assumes load is not asserted while a window is being timed.
module sram_tick_timer #(
    parameter int unsigned CNT_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    output logic             done
);

    logic [CNT_W-1:0] cnt_q;

    // Load a new window length, otherwise count down to zero and stop there.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (load) begin
            cnt_q <= load_val;
        end else if (cnt_q != '0) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    assign done = (cnt_q == '0);

endmodule

// File: rtl/sram_lane_path.sv
// Per-lane pin registers and the read capture path.
// Takes the next-cycle access, drive and select values from the sequencer and
// registers them, so every lane pin is glitch-free. An unselected lane reads as zero.
module sram_lane_path #(
    parameter int unsigned LANES  = 2,
    parameter int unsigned LANE_W = 8
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic [LANES-1:0]        sel_d,
    input  logic                    act_d,
    input  logic                    drive_d,
    input  logic                    capture,
    input  logic [LANES*LANE_W-1:0] wdata,
    input  logic [LANES*LANE_W-1:0] dq_in,
    output logic [LANES-1:0]        be_n,
    output logic [LANES-1:0]        dq_oe,
    output logic [LANES*LANE_W-1:0] dq_out,
    output logic [LANES*LANE_W-1:0] rdata
);

    assign dq_out = wdata;

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        // Lane enable, lane driver and lane capture register for one byte lane.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                be_n[g]                      <= 1'b1;
                dq_oe[g]                     <= 1'b0;
                rdata[g*LANE_W +: LANE_W]    <= '0;
            end else begin
                be_n[g]  <= !(act_d && sel_d[g]);
                dq_oe[g] <= drive_d && sel_d[g];
                if (capture) begin
                    rdata[g*LANE_W +: LANE_W] <= sel_d[g] ? dq_in[g*LANE_W +: LANE_W] : '0;
                end
            end
        end

        AST_LANE_DRV_SEL: assert property (@(posedge clk) disable iff (!rst_n)
            dq_oe[g] |-> !be_n[g]); // R3
    end

endmodule

// File: rtl/sram_lane_ctrl.sv
// Byte-lane asynchronous SRAM controller (top).
// Sequences chip select, lane enables, write and output enables from a
// request/ready host port. Window lengths come from nanosecond parameters and
// the clock period. Assumes the host holds a request until rsp_ready.
module sram_lane_ctrl
    import sram_lane_pkg::*;
#(
    parameter int unsigned CLK_NS   = 8,
    parameter int unsigned ADDR_W   = 18,
    parameter int unsigned LANES    = 2,
    parameter int unsigned LANE_W   = 8,
    parameter int unsigned T_WP_NS  = 45,
    parameter int unsigned T_ACC_NS = 55,
    parameter int unsigned T_OHZ_NS = 20
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    req_valid,
    input  logic                    req_write,
    input  logic [ADDR_W-1:0]       req_addr,
    input  logic [LANES-1:0]        req_be,
    input  logic [LANES*LANE_W-1:0] req_wdata,
    output logic                    rsp_ready,
    output logic [LANES*LANE_W-1:0] rsp_rdata,
    output logic [ADDR_W-1:0]       mem_addr,
    output logic                    mem_ce_n,
    output logic                    mem_oe_n,
    output logic                    mem_we_n,
    output logic [LANES-1:0]        mem_be_n,
    output logic [LANES*LANE_W-1:0] mem_dq_out,
    output logic [LANES-1:0]        mem_dq_oe,
    input  logic [LANES*LANE_W-1:0] mem_dq_in
);

    localparam int unsigned DATA_W   = LANES * LANE_W;
    localparam int unsigned WR_CYC   = ns_to_cyc(T_WP_NS, CLK_NS);
    localparam int unsigned RD_CYC   = ns_to_cyc(T_ACC_NS, CLK_NS);
    localparam int unsigned TURN_CYC = ns_to_cyc(T_OHZ_NS, CLK_NS);
    localparam int unsigned TMR_MAX  = (WR_CYC > RD_CYC) ? WR_CYC : RD_CYC;
    localparam int unsigned TMR_W    = $clog2(TMR_MAX + 1);
    localparam int unsigned TURN_W   = $clog2(TURN_CYC + 1);

    ctrl_state_t         state_q, state_d;
    logic [ADDR_W-1:0]   addr_q;
    logic [LANES-1:0]    sel_q, sel_d;
    logic [DATA_W-1:0]   wdata_q;
    logic                ce_n_q, we_n_q, oe_n_q, ready_q;
    logic [TURN_W-1:0]   turn_q;
    logic                tmr_load, tmr_done;
    logic [TMR_W-1:0]    tmr_val;
    logic                accept, bypass, capture, turn_ok;
    logic                act_d, drive_d;

    assign accept  = (state_q == ST_IDLE) && req_valid;
    assign bypass  = accept && (req_be == '0);
    assign turn_ok = (turn_q >= TURN_W'(TURN_CYC));
    assign sel_d   = accept ? req_be : sel_q;
    assign act_d   = (state_d == ST_WSETUP) || (state_d == ST_WPULSE) ||
                     (state_d == ST_WHOLD)  || (state_d == ST_RACC);
    assign drive_d = (state_d == ST_WPULSE) || (state_d == ST_WHOLD);

    // Next-state decode, window timer loads and capture strobe.
    always_comb begin
        state_d  = state_q;
        tmr_load = 1'b0;
        tmr_val  = '0;
        capture  = 1'b0;
        case (state_q)
            ST_IDLE: begin
                if (bypass) begin
                    state_d = ST_RECOVER;
                    capture = 1'b1;
                end else if (accept && req_write) begin
                    state_d = ST_WSETUP;
                end else if (accept) begin
                    state_d  = ST_RACC;
                    tmr_load = 1'b1;
                    tmr_val  = TMR_W'(RD_CYC - 1);
                end
            end
            ST_WSETUP: begin
                if (turn_ok) begin
                    state_d  = ST_WPULSE;
                    tmr_load = 1'b1;
                    tmr_val  = TMR_W'(WR_CYC - 1);
                end
            end
            ST_WPULSE:  if (tmr_done) state_d = ST_WHOLD;
            ST_WHOLD:   state_d = ST_RECOVER;
            ST_RACC: begin
                if (tmr_done) begin
                    state_d = ST_RECOVER;
                    capture = 1'b1;
                end
            end
            ST_RECOVER: state_d = ST_IDLE;
            default:    state_d = ST_IDLE;
        endcase
    end

    // State, strobe registers and request capture.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            ce_n_q  <= 1'b1;
            we_n_q  <= 1'b1;
            oe_n_q  <= 1'b1;
            ready_q <= 1'b0;
            addr_q  <= '0;
            sel_q   <= '0;
            wdata_q <= '0;
        end else begin
            state_q <= state_d;
            ce_n_q  <= !act_d;
            we_n_q  <= !(state_d == ST_WPULSE);
            oe_n_q  <= !(state_d == ST_RACC);
            ready_q <= capture || (state_q == ST_WHOLD);
            sel_q   <= sel_d;
            if (accept) begin
                addr_q  <= req_addr;
                wdata_q <= req_wdata;
            end
        end
    end

    // Counts cycles with output enable high, saturating at the turnaround length.
    always_ff @(posedge clk) begin
        if (!rst_n || !oe_n_q) begin
            turn_q <= '0;
        end else if (!turn_ok) begin
            turn_q <= turn_q + 1'b1;
        end
    end

    sram_tick_timer #(.CNT_W(TMR_W)) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (tmr_load),
        .load_val (tmr_val),
        .done     (tmr_done)
    );

    sram_lane_path #(.LANES(LANES), .LANE_W(LANE_W)) u_lanes (
        .clk      (clk),
        .rst_n    (rst_n),
        .sel_d    (sel_d),
        .act_d    (act_d),
        .drive_d  (drive_d),
        .capture  (capture),
        .wdata    (wdata_q),
        .dq_in    (mem_dq_in),
        .be_n     (mem_be_n),
        .dq_oe    (mem_dq_oe),
        .dq_out   (mem_dq_out),
        .rdata    (rsp_rdata)
    );

    assign mem_addr  = addr_q;
    assign mem_ce_n  = ce_n_q;
    assign mem_we_n  = we_n_q;
    assign mem_oe_n  = oe_n_q;
    assign rsp_ready = ready_q;

    AST_ADDR_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
        (!mem_ce_n && $past(!mem_ce_n)) |-> $stable(mem_addr)); // R1
    AST_WE_NEEDS_SELECT: assert property (@(posedge clk) disable iff (!rst_n)
        !mem_we_n |-> (!mem_ce_n && (mem_be_n != '1))); // R2
    AST_WE_OE_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        !mem_we_n |-> mem_oe_n); // R2
    AST_NO_CONTENTION: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_dq_oe != '0) |-> mem_oe_n); // R4
    AST_WE_OPENS_LAST: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(mem_we_n) |-> $past(!mem_ce_n)); // R6
    AST_READY_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_ready |=> !rsp_ready); // R8
    AST_RESET_STROBES: assert property (@(posedge clk)
        !rst_n |=> (mem_ce_n && mem_we_n && mem_oe_n && (mem_dq_oe == '0) && !rsp_ready)); // R9

endmodule

// File: tb/sram_lane_ctrl_tb.sv
module sram_lane_ctrl_tb;

    localparam int CLK_NS   = 8;
    localparam int WR_CYC   = (45 + CLK_NS - 1) / CLK_NS + 1;
    localparam int RD_CYC   = (55 + CLK_NS - 1) / CLK_NS + 1;
    localparam int TURN_CYC = (20 + CLK_NS - 1) / CLK_NS + 1;
    localparam int NVEC     = 16;

    // {write, addr[17:0], be[1:0], wdata[15:0], expected read[15:0]}
    localparam logic [52:0] VEC [NVEC] = '{
        {1'b1, 18'h00010, 2'b11, 16'h1234, 16'h0000},
        {1'b0, 18'h00010, 2'b11, 16'h0000, 16'h1234},
        {1'b1, 18'h00010, 2'b10, 16'hABCD, 16'h0000},
        {1'b0, 18'h00010, 2'b11, 16'h0000, 16'hAB34},
        {1'b1, 18'h00010, 2'b01, 16'h99EF, 16'h0000},
        {1'b0, 18'h00010, 2'b01, 16'h0000, 16'h00EF},
        {1'b0, 18'h00010, 2'b10, 16'h0000, 16'hAB00},
        {1'b1, 18'h3FFFF, 2'b11, 16'hFFFF, 16'h0000},
        {1'b0, 18'h3FFFF, 2'b11, 16'h0000, 16'hFFFF},
        {1'b1, 18'h00021, 2'b00, 16'h5555, 16'h0000},
        {1'b0, 18'h00021, 2'b11, 16'h0000, 16'h0000},
        {1'b0, 18'h00010, 2'b00, 16'h0000, 16'h0000},
        {1'b1, 18'h00022, 2'b11, 16'h0F0F, 16'h0000},
        {1'b1, 18'h00023, 2'b11, 16'hF0F0, 16'h0000},
        {1'b0, 18'h00022, 2'b11, 16'h0000, 16'h0F0F},
        {1'b0, 18'h00023, 2'b11, 16'h0000, 16'hF0F0}
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0, req_write = 1'b0;
    logic [17:0] req_addr = '0;
    logic [1:0]  req_be = '0;
    logic [15:0] req_wdata = '0;
    logic        rsp_ready;
    logic [15:0] rsp_rdata;
    logic [17:0] mem_addr;
    logic        mem_ce_n, mem_oe_n, mem_we_n;
    logic [1:0]  mem_be_n, mem_dq_oe;
    logic [15:0] mem_dq_out, mem_dq_in;

    int errors = 0, checks = 0;
    bit done = 0;

    always #(CLK_NS/2) clk = ~clk;

    sram_lane_ctrl u_dut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
        .req_addr(req_addr), .req_be(req_be), .req_wdata(req_wdata),
        .rsp_ready(rsp_ready), .rsp_rdata(rsp_rdata), .mem_addr(mem_addr),
        .mem_ce_n(mem_ce_n), .mem_oe_n(mem_oe_n), .mem_we_n(mem_we_n),
        .mem_be_n(mem_be_n), .mem_dq_out(mem_dq_out), .mem_dq_oe(mem_dq_oe),
        .mem_dq_in(mem_dq_in)
    );

    task automatic chk(input bit ok, input string rq, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual=%0h expected=%0h", rq, act, exp);
        end
    endtask

    // Memory model, sampled away from the active edge.
    logic [15:0] mem [256];
    logic [17:0] cur_addr = '0;
    bit  ce_seen = 0, ce_gap = 1;
    int  olc = 0, ohi = 0, wlow = 0;
    logic prev_we_n = 1'b1, prev_ce_n = 1'b1;
    logic [1:0] prev_be_n = 2'b11, prev_oe = 2'b00;

    initial for (int i = 0; i < 256; i++) mem[i] = 16'h0000;

    for (genvar g = 0; g < 2; g++) begin : g_bus
        assign mem_dq_in[g*8 +: 8] =
            (!mem_ce_n && !mem_oe_n && mem_we_n && !mem_be_n[g]) ?
                ((olc >= RD_CYC) ? mem[mem_addr[7:0]][g*8 +: 8] : 8'hDE) : 8'hA5;
    end

    always @(negedge clk) begin
        if (rst_n) begin
            if (!mem_ce_n) ce_seen = 1;
            if (mem_ce_n) ce_gap = 1;
            if (mem_dq_oe != 2'b00 && !mem_oe_n)
                chk(0, "R4 contention", {30'd0, mem_dq_oe}, 0);
            if (mem_dq_oe != 2'b00 && prev_oe == 2'b00)
                chk(ohi >= TURN_CYC, "R4 turnaround", ohi, TURN_CYC);
            if (prev_we_n && !mem_we_n) begin
                chk(!prev_ce_n && prev_be_n != 2'b11, "R6 window opens last", {prev_ce_n, prev_be_n}, 0);
                chk(ce_gap, "R6 chip select gap", ce_gap, 1);
                ce_gap = 0;
            end
            if (!mem_we_n) begin
                wlow++;
                if (mem_dq_oe != ~mem_be_n)
                    chk(0, "R3 lane drive", {mem_dq_oe, mem_be_n}, {~mem_be_n, mem_be_n});
            end
            if (!prev_we_n && mem_we_n) begin
                chk(wlow >= WR_CYC, "R2 pulse width", wlow, WR_CYC);
                chk(mem_addr == cur_addr, "R1 write address", mem_addr, cur_addr);
                chk(!mem_ce_n, "R6 window closes first", mem_ce_n, 0);
                if (!prev_be_n[0]) mem[mem_addr[7:0]][7:0]  = mem_dq_out[7:0];
                if (!prev_be_n[1]) mem[mem_addr[7:0]][15:8] = mem_dq_out[15:8];
            end
            if (mem_we_n) wlow = 0;
        end else begin
            wlow = 0;
        end
        olc = (!mem_ce_n && !mem_oe_n && mem_we_n) ? olc + 1 : 0;
        ohi = mem_oe_n ? ohi + 1 : 0;
        prev_we_n = mem_we_n;
        prev_ce_n = mem_ce_n;
        prev_be_n = mem_be_n;
        prev_oe   = mem_dq_oe;
    end

    task automatic do_req(input logic [52:0] v);
        int  t;
        bit  got;
        string rq;
        rq = (v[33:32] == 2'b00) ? "R7" : (v[33:32] != 2'b11) ? "R3" : "R5";
        @(negedge clk);
        req_valid = 1; req_write = v[52]; req_addr = v[51:34];
        req_be = v[33:32]; req_wdata = v[31:16];
        cur_addr = v[51:34]; ce_seen = 0;
        got = 0;
        for (t = 0; t < 100 && !got; t++) begin
            @(negedge clk);
            if (rsp_ready) got = 1;
        end
        req_valid = 0;
        chk(got, "R8 ready arrives", got, 1);
        if (!v[52]) chk(rsp_rdata == v[15:0], rq, rsp_rdata, v[15:0]);
        if (v[33:32] == 2'b00) chk(!ce_seen, "R7 no strobe", ce_seen, 0);
        else if (!v[52]) chk(mem_addr == cur_addr, "R1 read address", mem_addr, cur_addr);
        @(negedge clk);
        chk(!rsp_ready, "R8 single pulse", rsp_ready, 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        chk(mem_ce_n && mem_we_n && mem_oe_n, "R9 reset strobes", {mem_ce_n, mem_we_n, mem_oe_n}, 3'b111);
        chk(mem_dq_oe == 0 && !rsp_ready, "R9 reset drivers", {mem_dq_oe, rsp_ready}, 0);
        chk(mem_be_n == 2'b11, "R9 reset lanes", mem_be_n, 2'b11);

        for (int i = 0; i < NVEC; i++) do_req(VEC[i]);

        // Reset in the middle of a write pulse.
        @(negedge clk);
        req_valid = 1; req_write = 1; req_addr = 18'h00055; req_be = 2'b11; req_wdata = 16'h7777;
        cur_addr = 18'h00055;
        for (int t = 0; t < 50 && mem_we_n; t++) @(negedge clk);
        chk(!mem_we_n, "R2 write started", mem_we_n, 0);
        req_valid = 0;
        rst_n = 0;
        @(negedge clk);
        chk(mem_ce_n && mem_we_n && mem_oe_n && mem_be_n == 2'b11, "R9 mid-write reset",
            {mem_ce_n, mem_we_n, mem_oe_n, mem_be_n}, 5'b11111);
        chk(mem_dq_oe == 0 && !rsp_ready, "R9 mid-write drivers", {mem_dq_oe, rsp_ready}, 0);
        @(negedge clk);
        rst_n = 1;
        do_req({1'b0, 18'h00010, 2'b11, 16'h0000, 16'hABEF});

        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        #(CLK_NS * 20000);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

endmodule